// File: doc/BRIEF.md
# Flash Reset Pattern Generator

This block produces a fixed, slow signalling pattern on a serial flash's chip-select and first data line. It runs once at bring-up, before the normal SPI controller takes the pins. The pattern puts the flash back into a known state, whatever mode a previous boot left it in. A single-cycle start pulse launches the sequence. The block then works through a preamble, a run of chip-select low pulses and a trailing high phase. It raises a one-cycle completion flag and then parks both pins high.

Every phase lasts the same hold time. The hold time is set in microseconds (`HOLD_US`). The clock rate is given as `CYC_PER_US`, the number of clock cycles per microsecond. Their product is the length of each phase in clock cycles. During each low pulse the data line carries bit 0 of that pulse's index, so the line alternates from one pulse to the next. The pin outputs are registered, which keeps the pads free of glitches. Control and status are plain level pins, with no handshake.

Top module: `flash_reset_seq`

## Requirements
- R1: While reset is held, and in the idle state with no start, `cs_no` = 1, `io0_o` = 1 and `done_o` = 0.
- R2: The block accepts a start when `start_i` is high at a rising clock edge while it is idle. Because the pins are registered, the pin timeline begins one cycle after that edge. It opens with a preamble of HOLD_CYC = HOLD_US × CYC_PER_US cycles with both `cs_no` and `io0_o` high.
- R3: Each sequence contains exactly PULSES falling edges of `cs_no` (default 4).
- R4: Each low pulse of `cs_no` lasts exactly HOLD_CYC cycles. A high phase of exactly HOLD_CYC cycles follows it.
- R5: During pulse i (counted from 0), `io0_o` equals bit 0 of i, giving 0, 1, 0, 1. It keeps that value through the high phase that follows the pulse.
- R6: In the cycle right after the last high phase, `done_o` is high for exactly one cycle with `cs_no` = 1 and `io0_o` = 1. The block is idle afterwards.
- R7: A start that arrives while a sequence is running, including its completion cycle, is ignored. The pin timeline stays exactly as it would be without it.
- R8: Once the block is idle again, a new start produces a complete fresh sequence whose first pulse drives `io0_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, CYC_PER_US cycles per microsecond |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, sampled at the rising edge |
| cs_no | output | 1 | Flash chip-select, active low, idles high |
| io0_o | output | 1 | Flash data line 0, idles high |
| done_o | output | 1 | One-cycle flag marking the end of the sequence |

## Verification
The bound checker watches the pins on every cycle. It checks that each low pulse is exactly one hold time long and that the data line sits at the right level when chip-select falls and stays steady while it is low. It also checks that completion is a single cycle with both pins high and that exactly the configured number of pulses came before it. The checker cannot see when a sequence begins. Only the bench's scenarios can show that the preamble has the right length relative to the accepted start, that starts arriving mid-sequence or during completion leave the timeline untouched, and that a later start repeats the whole pattern from pulse zero.

// File: rtl/flrst_pkg.sv
package flrst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_LOW  = 3'd2,
    ST_HIGH = 3'd3,
    ST_DONE = 3'd4
  } flrst_state_e;

  typedef struct packed {
    logic cs_n;
    logic io0;
    logic done;
  } flrst_pins_t;

  localparam flrst_pins_t PINS_IDLE = '{cs_n: 1'b1, io0: 1'b1, done: 1'b0};

endpackage

// File: rtl/flrst_timer.sv
// Phase timer: a load sets it to LOAD-1; it counts down to zero and holds there.
module flrst_timer #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned LOAD  = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CNT_W'(LOAD - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/flrst_seq.sv
// Phase sequencer: preamble, then PULSES low/high pairs, then one completion cycle.
module flrst_seq
  import flrst_pkg::*;
#(
  parameter int unsigned PULSES = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         expired_i,
  output flrst_state_e state_o,
  output logic         pat_bit_o,
  output logic         load_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PULSES - 1);

  flrst_state_e     state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    load_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_PRE;
          idx_d   = '0;
          load_o  = 1'b1;
        end
      end
      ST_PRE: begin
        if (expired_i) begin
          state_d = ST_LOW;
          load_o  = 1'b1;
        end
      end
      ST_LOW: begin
        if (expired_i) begin
          state_d = ST_HIGH;
          load_o  = 1'b1;
        end
      end
      ST_HIGH: begin
        if (expired_i) begin
          if (idx_q == LAST_IDX) begin
            state_d = ST_DONE;
          end else begin
            idx_d   = idx_q + IDX_W'(1);
            state_d = ST_LOW;
            load_o  = 1'b1;
          end
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
        idx_d   = '0;
      end
      default: begin
        state_d = ST_IDLE;
        idx_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign state_o   = state_q;
  assign pat_bit_o = idx_q[0];

endmodule

// File: rtl/flrst_pins.sv
// Registered pin stage: decodes the phase into pad levels one cycle later.
module flrst_pins
  import flrst_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  flrst_state_e state_i,
  input  logic         pat_bit_i,
  output logic         cs_no,
  output logic         io0_o,
  output logic         done_o
);

  flrst_pins_t pins_d, pins_q;

  always_comb begin
    pins_d = PINS_IDLE;
    case (state_i)
      ST_LOW: begin
        pins_d.cs_n = 1'b0;
        pins_d.io0  = pat_bit_i;
      end
      ST_HIGH: begin
        pins_d.io0  = pat_bit_i;
      end
      ST_DONE: begin
        pins_d.done = 1'b1;
      end
      default: pins_d = PINS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_q <= PINS_IDLE;
    end else begin
      pins_q <= pins_d;
    end
  end

  assign cs_no  = pins_q.cs_n;
  assign io0_o  = pins_q.io0;
  assign done_o = pins_q.done;

endmodule

// File: rtl/flash_reset_seq.sv
module flash_reset_seq
  import flrst_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned HOLD_US    = 300,
  parameter int unsigned PULSES     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic cs_no,
  output logic io0_o,
  output logic done_o
);

  localparam int unsigned HOLD_CYC = HOLD_US * CYC_PER_US;
  localparam int unsigned CNT_W    = $clog2(HOLD_CYC + 1);
  localparam int unsigned IDX_W    = (PULSES > 1) ? $clog2(PULSES) : 1;

  flrst_state_e state;
  logic         pat_bit;
  logic         load;
  logic         expired;

  flrst_timer #(
    .CNT_W (CNT_W),
    .LOAD  (HOLD_CYC)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .expired_o (expired)
  );

  flrst_seq #(
    .PULSES (PULSES),
    .IDX_W  (IDX_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .expired_i (expired),
    .state_o   (state),
    .pat_bit_o (pat_bit),
    .load_o    (load)
  );

  flrst_pins u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .pat_bit_i (pat_bit),
    .cs_no     (cs_no),
    .io0_o     (io0_o),
    .done_o    (done_o)
  );

endmodule

// File: rtl/flrst_checker.sv
module flrst_checker #(
  parameter int unsigned HOLD_CYC = 1,
  parameter int unsigned PULSES   = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic io0_o,
  input logic done_o
);

  int unsigned low_run;
  int unsigned fall_cnt;
  logic        cs_q;
  logic        cs_fall;

  assign cs_fall = cs_q && !cs_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run  <= 0;
      fall_cnt <= 0;
      cs_q     <= 1'b1;
    end else begin
      cs_q    <= cs_no;
      low_run <= cs_no ? 0 : low_run + 1;
      if (done_o)       fall_cnt <= 0;
      else if (cs_fall) fall_cnt <= fall_cnt + 1;
    end
  end

  AST_LOW_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> low_run == HOLD_CYC); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6

  AST_DONE_PINS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && io0_o)); // R6

  AST_PULSE_TOTAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fall_cnt == PULSES); // R3

  AST_PULSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_cnt <= PULSES); // R3

  AST_IO0_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |-> io0_o == fall_cnt[0]); // R5

  AST_IO0_HOLD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_q && !cs_no) |-> $stable(io0_o)); // R5

endmodule

bind flash_reset_seq flrst_checker #(
  .HOLD_CYC (HOLD_CYC),
  .PULSES   (PULSES)
) u_flrst_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_no  (cs_no),
  .io0_o  (io0_o),
  .done_o (done_o)
);

// File: tb/test_flash_reset_seq.sv
`timescale 1ns/1ps
module test_flash_reset_seq;

  localparam int CYC_PER_US = 1;
  localparam int HOLD_US    = 12;
  localparam int PULSES     = 4;
  localparam int H          = HOLD_US * CYC_PER_US;
  localparam int SEQ        = (1 + 2 * PULSES) * H;

  logic clk;
  logic rst_n;
  logic start;
  logic cs_n;
  logic io0;
  logic done;

  int cyc;
  int n_checks;
  int n_fails;

  flash_reset_seq #(
    .CYC_PER_US (CYC_PER_US),
    .HOLD_US    (HOLD_US),
    .PULSES     (PULSES)
  ) i_flash_reset_seq (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .cs_no   (cs_n),
    .io0_o   (io0),
    .done_o  (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check3(input string req, input string tag,
                        input bit ecs, input bit eio, input bit edn);
    n_checks++;
    if (cs_n !== ecs || io0 !== eio || done !== edn) begin
      n_fails++;
      $display("FAIL %s %s cyc=%0d actual cs=%b io0=%b done=%b expected cs=%b io0=%b done=%b",
               req, tag, cyc, cs_n, io0, done, ecs, eio, edn);
    end
  endtask

  // Expected pins for a state that entered `rel` edges after the accepting edge.
  task automatic expect_at(input int rel, output bit ecs, output bit eio,
                           output bit edn, output string req);
    int k;
    int p;
    ecs = 1'b1; eio = 1'b1; edn = 1'b0; req = "R1";
    if (rel == SEQ) begin
      edn = 1'b1; req = "R6";
    end else if (rel >= 0 && rel < SEQ) begin
      k = rel / H;
      if (k == 0) begin
        req = "R2";
      end else begin
        p   = (k - 1) / 2;
        ecs = ((k - 1) % 2) != 0;
        eio = p[0];
        req = "R4 R5";
      end
    end
  endtask

  task automatic t_reset();
    bit ecs, eio, edn;
    string req;
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check3("R1", "in reset", 1'b1, 1'b1, 1'b0);
    end
    rst_n = 1'b1;
    repeat (10) begin
      @(negedge clk);
      expect_at(-1, ecs, eio, edn, req);
      check3(req, "idle after reset", ecs, eio, edn);
    end
  endtask

  // One full sequence; inj_* are offsets of extra start pulses (-1 = none).
  task automatic t_run(input string tag, input int inj_a, input int inj_b, input int inj_c);
    int  n0;
    int  falls;
    int  rel_s;
    bit  cs_prev;
    bit  ecs, eio, edn;
    string req;
    @(negedge clk);
    start   = 1'b1;
    n0      = cyc + 1;
    falls   = 0;
    cs_prev = 1'b1;
    for (int n = n0; n <= n0 + SEQ + 3; n++) begin
      @(negedge clk);
      rel_s = cyc + 1 - n0;
      start = (rel_s == inj_a) || (rel_s == inj_b) || (rel_s == inj_c);
      expect_at(cyc - 1 - n0, ecs, eio, edn, req);
      check3(req, tag, ecs, eio, edn);
      if (cs_prev && !cs_n) falls++;
      cs_prev = cs_n;
    end
    start = 1'b0;
    n_checks++;
    if (falls != PULSES) begin
      n_fails++;
      $display("FAIL R3 %s pulse count actual %0d expected %0d", tag, falls, PULSES);
    end
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    rst_n    = 1'b0;
    start    = 1'b0;
    t_reset();
    t_run("R2 basic sequence", -1, -1, -1);
    // R7: starts in the preamble, mid low pulse and in the completion cycle
    t_run("R7 start ignored while running", H / 2, H + 3, SEQ + 1);
    // R7: start held high over several leading cycles
    t_run("R7 start held", 1, 2, 3);
    // R8: fresh sequence right after the previous one returned to idle
    t_run("R8 restart", -1, -1, -1);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired at cyc=%0d", cyc);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule